// File: doc/BRIEF.md
# Bidirectional dual-port bus shift register

This block is a word-wide storage and shift register placed between two parallel ports, A and B. It can pass a word from either port to the other. It can gather serial bits into a word and present that word on either port. It can hold a stored word, or take a word from a port and send it out one bit at a time.

Each port has separate input, output and output-enable vectors, so an enclosing wrapper can turn them into tri-state pins. A direction control picks the input port, and the other port drives the stored word. Port A also has its own enable, which releases it from the bus so that several registers can share one bus.

The block runs on a fast system clock `clk`. The register's own clock arrives as the sampled input `shift_clk`, and only its rising transitions count. A parallel load can wait for such a transition, or it can follow the input port on every system cycle. Serial shifting always waits for the transition.

Top module: `bidir_bus_shreg`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, all stages clear to 0. While `rst_n` is low, `a_oe` and `b_oe` are all zeros.
- R2: With `dir_a2b`=1, `b_oe` is all ones and `a_oe` is all zeros. `a_out` and `b_out` always carry the stored word.
- R3: With `dir_a2b`=0, `b_oe` is all zeros. `a_oe` is all ones when `a_en`=1 and all zeros when `a_en`=0.
- R4: With `par_sel`=1 and `async_sel`=0, the word from the input port is loaded only in a `clk` cycle in which `shift_clk` goes from 0 to 1. In every other cycle the word is unchanged.
- R5: With `par_sel`=1 and `async_sel`=1, the register takes the input port's word one `clk` cycle after it is presented, whatever `shift_clk` does.
- R6: With `par_sel`=0, each 0-to-1 transition of `shift_clk` moves every stage one place toward bit W-1 and puts `ser_in` into bit 0. `ser_out` shows bit W-1. `async_sel` has no effect in this mode.
- R7: With `par_sel`=1, `dir_a2b`=1 and `a_en`=0, the stored word is held in both load timings.
- R8: With `dir_a2b`=0, a parallel load takes `b_in` whatever the value of `a_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| a_en | input | 1 | port A participation enable |
| dir_a2b | input | 1 | 1: A is input and B drives; 0: B is input and A drives |
| async_sel | input | 1 | 1: parallel load follows the input port every cycle |
| par_sel | input | 1 | 1: parallel load; 0: serial shift |
| shift_clk | input | 1 | register clock, acted on at its rising transitions |
| ser_in | input | 1 | serial data into bit 0 |
| a_in | input | W | port A incoming word |
| b_in | input | W | port B incoming word |
| a_out | output | W | port A outgoing word |
| a_oe | output | W | port A drive enables |
| b_out | output | W | port B outgoing word |
| b_oe | output | W | port B drive enables |
| ser_out | output | 1 | stage W-1 |

## Verification
A walk of vectors loads words with `shift_clk` held low, held high and rising. This separates a real edge detector from one that only looks at the level. Asynchronous loads are given different words in consecutive cycles with `shift_clk` both low and high, which shows that the load follows the port rather than the clock. Hold cases use `a_en`=0 with A as the input, and a B load uses `a_en`=0, which shows that the enable gates only port A. Serial runs use alternating `ser_in` bits with both `async_sel` values, which exposes a shift in the wrong direction or an asynchronous shift.

// File: rtl/bidir_bus_shreg.sv
module bidir_bus_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_en,
  input  logic         dir_a2b,
  input  logic         async_sel,
  input  logic         par_sel,
  input  logic         shift_clk,
  input  logic         ser_in,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe,
  output logic         ser_out
);

  logic [W-1:0] stages;
  logic         sclk_q;
  logic         rise;
  logic         load_ok;
  logic [W-1:0] src;

  assign rise    = shift_clk & ~sclk_q;
  assign src     = dir_a2b ? a_in : b_in;
  assign load_ok = ~dir_a2b | a_en;

  always_ff @(posedge clk) begin
    sclk_q <= shift_clk;
    if (!rst_n)
      stages <= '0;
    else if (par_sel) begin
      if (load_ok && (async_sel || rise))
        stages <= src;
    end else if (rise)
      stages <= {stages[W-2:0], ser_in};
  end

  assign a_out   = stages;
  assign b_out   = stages;
  assign ser_out = stages[W-1];
  assign a_oe    = {W{rst_n & ~dir_a2b & a_en}};
  assign b_oe    = {W{rst_n & dir_a2b}};

  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> stages == '0);
  a_r1_oe_off: assert property (@(posedge clk) !rst_n |-> (a_oe == '0 && b_oe == '0));
  a_r2_b_drives: assert property (@(posedge clk) disable iff (!rst_n)
    dir_a2b |-> (b_oe == '1 && a_oe == '0));
  a_r3_a_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_a2b) |-> (b_oe == '0 && a_oe == {W{a_en}}));
  a_r4_no_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (par_sel && !async_sel && !(shift_clk && !sclk_q)) |=> $stable(stages));
  a_r6_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_sel && shift_clk && !sclk_q) |=> stages == {$past(stages[W-2:0]), $past(ser_in)});
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (par_sel && dir_a2b && !a_en) |=> $stable(stages));

endmodule

// File: tb/bidir_bus_shreg_test.sv
module bidir_bus_shreg_test;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, a_en = 0, dir_a2b = 0, async_sel = 0, par_sel = 0;
  logic shift_clk = 0, ser_in = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;
  logic ser_out;
  int checks = 0, failures = 0;

  bidir_bus_shreg #(.W(W)) uut (.*);

  always #2 clk = ~clk;

  // {par, async, dir, aen, sclk, ser, a_in, b_in, expected word}
  localparam logic [29:0] VEC [15] = '{
    {6'b101100, 8'hA5, 8'h00, 8'h00},  // R4 level low
    {6'b101110, 8'hA5, 8'h00, 8'hA5},  // R4 rise
    {6'b101110, 8'h3C, 8'h00, 8'hA5},  // R4 held high
    {6'b101100, 8'h3C, 8'h00, 8'hA5},  // R4 fall
    {6'b100010, 8'h3C, 8'h96, 8'h96},  // R8 B load, a_en=0
    {6'b111100, 8'h5A, 8'h00, 8'h5A},  // R5
    {6'b111110, 8'hC3, 8'h00, 8'hC3},  // R5
    {6'b111000, 8'hFF, 8'h00, 8'hC3},  // R7 async hold
    {6'b101010, 8'hFF, 8'h11, 8'hC3},  // R7 sync hold
    {6'b011101, 8'h00, 8'h00, 8'hC3},  // R6 no edge
    {6'b011111, 8'h00, 8'h00, 8'h87},  // R6 shift, async ignored
    {6'b001100, 8'h00, 8'h00, 8'h87},  // R6
    {6'b001110, 8'h00, 8'h00, 8'h0E},  // R6
    {6'b001101, 8'h00, 8'h00, 8'h0E},  // R6
    {6'b001111, 8'h00, 8'h00, 8'h1D}   // R6
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    dir_a2b = 1; a_en = 1;
    repeat (3) @(negedge clk);
    chk("R1 word", b_out, 8'h00);
    chk("R1 a_oe", a_oe, 8'h00);
    chk("R1 b_oe", b_oe, 8'h00);
    rst_n = 1;
    @(negedge clk);
    for (int i = 0; i < 15; i++) begin
      {par_sel, async_sel, dir_a2b, a_en, shift_clk, ser_in} = VEC[i][29:24];
      a_in = VEC[i][23:16];
      b_in = VEC[i][15:8];
      @(negedge clk);
      chk($sformatf("R4/R5/R6/R7/R8 vec%0d word", i), b_out, VEC[i][7:0]);
      chk($sformatf("R6 vec%0d ser_out", i), {7'b0, ser_out}, {7'b0, VEC[i][7]});
      chk($sformatf("R2 vec%0d a_out", i), a_out, VEC[i][7:0]);
    end
    par_sel = 1; async_sel = 0; shift_clk = 0;
    dir_a2b = 1; a_en = 1; @(negedge clk);
    chk("R2 b_oe", b_oe, 8'hFF);
    chk("R2 a_oe", a_oe, 8'h00);
    dir_a2b = 0; @(negedge clk);
    chk("R3 a_oe on", a_oe, 8'hFF);
    chk("R3 b_oe off", b_oe, 8'h00);
    a_en = 0; @(negedge clk);
    chk("R3 a_oe off", a_oe, 8'h00);
    dir_a2b = 1; a_en = 1; async_sel = 1; a_in = 8'h77; @(negedge clk);
    chk("R5 load", b_out, 8'h77);
    rst_n = 0; @(negedge clk);
    chk("R1 clear", b_out, 8'h00);
    chk("R1 b_oe in reset", b_oe, 8'h00);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule